// File: doc/BRIEF.md
# Self-Timed Serial Sample Source

This block stands in for the digital side of a 12-bit serial converter. A host lowers an active-low select line to start a conversion. The block then captures the word on its parallel sample port and drives its serial output low for a fixed, self-timed busy period. At the end of that period it raises the output as a ready marker. From then on, each falling edge of the host's serial clock moves the frame one bit: first the data MSB, then the other bits down to the LSB. After the LSB the line carries zeros for as long as select stays low.

Select, serial clock and a low-active power-down input are all asynchronous to the system clock. They pass through synchronizers and are edge-detected inside the block. Every timing value is a parameter counted in system-clock cycles: the busy period, the minimum select-high time, the longer recovery time after an aborted conversion, and the wake-up time after power-down. The output is a data bit plus a drive enable. A pad buffer outside the block turns the pair into a three-state line.

Top module: `serial_adc_emu`

## Requirements
- R1: While the synchronized select is high, `dout_oe_o` is 0 (the line is undriven) from the next cycle on.
- R2: A start accepted on a falling select edge sets `dout_oe_o`=1 and `dout_o`=0 SYNC_STAGES+1 cycles after the pin falls. It captures `sample_i` at that cycle, and later changes to `sample_i` do not alter the frame.
- R3: The busy period lasts CONV_CYC cycles, then `dout_o` goes to 1 as the ready marker.
- R4: In the readout phase `dout_o` changes only after a falling serial-clock edge. Successive falls present sample bits 11 down to 0.
- R5: Falling edges after the LSB, with select still low, present 0 and leave `dout_oe_o` at 1.
- R6: Select going high during the busy period ends the conversion. The next start needs select to have been high for at least ACQ_CYC cycles; ACQ_CYC-1 cycles are rejected.
- R7: Otherwise a start needs select high for at least CSH_CYC consecutive cycles before the fall; CSH_CYC-1 is rejected.
- R8: While `shdn_n_i` is low, any conversion or readout stops, the line is undriven and starts are ignored.
- R9: After `shdn_n_i` returns high, a select fall arriving WAKE_CYC-1 cycles later is ignored and one arriving WAKE_CYC cycles later is accepted.
- R10: Any serial-clock edge during the busy period sets `proto_err_o`, which stays set until the next accepted start. It does not disturb the frame.
- R11: After reset `dout_oe_o` and `proto_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Asynchronous active-low select / conversion start |
| sclk_i | input | 1 | Asynchronous host serial clock |
| shdn_n_i | input | 1 | Asynchronous active-low power-down |
| sample_i | input | DATA_W | Parallel value to be reported by the next conversion |
| dout_o | output | 1 | Serial data bit |
| dout_oe_o | output | 1 | Drive enable for the serial line (0 = high impedance) |
| proto_err_o | output | 1 | Sticky flag: serial clock toggled while busy |

## Verification
The bench builds the block with a 20-cycle busy period, a 5-cycle select-high minimum, a 12-cycle recovery after abort, a 15-cycle wake time and two synchronizer stages. The defaults correspond to microsecond figures at about 100 MHz. The short windows make every guard testable at its exact boundary, one cycle short and exactly met, and they keep the three-cycle pin-to-state latency easy to count in short scenarios. Four sample words, including all-zeros and all-ones, exercise the MSB-first order and the zero padding.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_SHIFT = 2'd2
    } conv_state_t;

    // Asynchronous pins grouped for the synchronizer bank
    typedef struct packed {
        logic shdn_n;
        logic sclk;
        logic cs_n;
    } pin_set_t;

    // Idle levels of the pins: powered up, clock low, deselected
    localparam pin_set_t PIN_IDLE = '{shdn_n: 1'b1, sclk: 1'b0, cs_n: 1'b1};

    // Bits needed to hold values 0..n
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_emu_sync.sv
module adc_emu_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] INIT  = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o
);

    logic [W-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= INIT;
                else     chain_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= INIT;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign level_o = chain_q[STAGES-1];

endmodule

// File: rtl/adc_emu_guard.sv
module adc_emu_guard
    import adc_emu_pkg::*;
#(
    parameter int unsigned CSH_CYC  = 50,
    parameter int unsigned ACQ_CYC  = 150,
    parameter int unsigned WAKE_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_lvl,      // synchronized select, 1 = deselected
    input  logic shdn_lvl,    // synchronized power-down, 0 = asleep
    input  logic abort_evt,   // conversion cut short this cycle
    input  logic start_evt,   // conversion accepted this cycle
    output logic permit_o
);

    localparam int unsigned GATE_MAX = max2(CSH_CYC, ACQ_CYC);
    localparam int unsigned HW       = cnt_w(GATE_MAX);
    localparam int unsigned WW       = cnt_w(WAKE_CYC);

    logic [HW-1:0] hi_cnt_q;
    logic [WW-1:0] wake_cnt_q;
    logic          aborted_q;
    logic [HW-1:0] need_hi;

    // Consecutive cycles of deselect, saturating
    always_ff @(posedge clk) begin
        if (rst)                           hi_cnt_q <= '0;
        else if (!cs_lvl)                  hi_cnt_q <= '0;
        else if (hi_cnt_q != HW'(GATE_MAX)) hi_cnt_q <= hi_cnt_q + 1'b1;
    end

    // Cycles since power-down release, saturating; starts awake
    always_ff @(posedge clk) begin
        if (rst)                             wake_cnt_q <= WW'(WAKE_CYC);
        else if (!shdn_lvl)                  wake_cnt_q <= '0;
        else if (wake_cnt_q != WW'(WAKE_CYC)) wake_cnt_q <= wake_cnt_q + 1'b1;
    end

    // An abort raises the deselect requirement until the next start
    always_ff @(posedge clk) begin
        if (rst)            aborted_q <= 1'b0;
        else if (abort_evt) aborted_q <= 1'b1;
        else if (start_evt) aborted_q <= 1'b0;
    end

    assign need_hi  = aborted_q ? HW'(ACQ_CYC) : HW'(CSH_CYC);
    assign permit_o = shdn_lvl && (hi_cnt_q >= need_hi) && (wake_cnt_q >= WW'(WAKE_CYC));

endmodule

// File: rtl/adc_emu_shifter.sv
module adc_emu_shifter #(
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              shift_i,
    output logic              bit_o
);

    // Marker bit on top of the data word; zeros enter from below
    logic [DATA_W:0] frame_q;

    always_ff @(posedge clk) begin
        if (rst)          frame_q <= '0;
        else if (load_i)  frame_q <= {1'b1, load_val_i};
        else if (shift_i) frame_q <= {frame_q[DATA_W-1:0], 1'b0};
    end

    assign bit_o = frame_q[DATA_W];

endmodule

// File: rtl/serial_adc_emu.sv
module serial_adc_emu
    import adc_emu_pkg::*;
#(
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned CONV_CYC    = 850,
    parameter int unsigned CSH_CYC     = 50,
    parameter int unsigned ACQ_CYC     = 150,
    parameter int unsigned WAKE_CYC    = 200,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              shdn_n_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              dout_o,
    output logic              dout_oe_o,
    output logic              proto_err_o
);

    localparam int unsigned PW = $bits(pin_set_t);
    localparam int unsigned CW = cnt_w(CONV_CYC);

    pin_set_t     pins_raw, pins_s;
    logic         cs_lvl, sclk_lvl, shdn_lvl;
    logic         cs_prev_q, sclk_prev_q;
    logic         cs_fall, sclk_rise, sclk_fall;
    logic         permit, start_ok, conv_done, abort_evt, stop_evt;
    conv_state_t  state_q, state_d;
    logic [CW-1:0] conv_cnt_q;
    logic         err_q;
    logic         frame_bit;

    assign pins_raw = '{shdn_n: shdn_n_i, sclk: sclk_i, cs_n: cs_n_i};

    adc_emu_sync #(
        .W      (PW),
        .STAGES (SYNC_STAGES),
        .INIT   (PIN_IDLE)
    ) i_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pins_raw),
        .level_o (pins_s)
    );

    assign cs_lvl   = pins_s.cs_n;
    assign sclk_lvl = pins_s.sclk;
    assign shdn_lvl = pins_s.shdn_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev_q   <= PIN_IDLE.cs_n;
            sclk_prev_q <= PIN_IDLE.sclk;
        end else begin
            cs_prev_q   <= cs_lvl;
            sclk_prev_q <= sclk_lvl;
        end
    end

    assign cs_fall   = cs_prev_q && !cs_lvl;
    assign sclk_rise = !sclk_prev_q && sclk_lvl;
    assign sclk_fall = sclk_prev_q && !sclk_lvl;

    adc_emu_guard #(
        .CSH_CYC  (CSH_CYC),
        .ACQ_CYC  (ACQ_CYC),
        .WAKE_CYC (WAKE_CYC)
    ) i_guard (
        .clk       (clk),
        .rst       (rst),
        .cs_lvl    (cs_lvl),
        .shdn_lvl  (shdn_lvl),
        .abort_evt (abort_evt),
        .start_evt (start_ok),
        .permit_o  (permit)
    );

    assign start_ok  = (state_q == ST_IDLE) && cs_fall && permit;
    assign stop_evt  = cs_lvl || !shdn_lvl;
    assign abort_evt = (state_q == ST_CONV) && cs_lvl;
    assign conv_done = (conv_cnt_q == CW'(CONV_CYC - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_ok) state_d = ST_CONV;
            ST_CONV: begin
                if (stop_evt)       state_d = ST_IDLE;
                else if (conv_done) state_d = ST_SHIFT;
            end
            ST_SHIFT: if (stop_evt) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)                    conv_cnt_q <= '0;
        else if (state_q != ST_CONV) conv_cnt_q <= '0;
        else if (!conv_done)        conv_cnt_q <= conv_cnt_q + 1'b1;
    end

    // Serial clock activity while busy is a host error
    always_ff @(posedge clk) begin
        if (rst)                                             err_q <= 1'b0;
        else if (start_ok)                                   err_q <= 1'b0;
        else if (state_q == ST_CONV && (sclk_rise || sclk_fall)) err_q <= 1'b1;
    end

    adc_emu_shifter #(
        .DATA_W (DATA_W)
    ) i_shift (
        .clk        (clk),
        .rst        (rst),
        .load_i     (start_ok),
        .load_val_i (sample_i),
        .shift_i    ((state_q == ST_SHIFT) && sclk_fall),
        .bit_o      (frame_bit)
    );

    assign dout_oe_o   = (state_q != ST_IDLE);
    assign dout_o      = (state_q == ST_SHIFT) ? frame_bit : 1'b0;
    assign proto_err_o = err_q;

endmodule

// File: rtl/serial_adc_emu_chk.sv
module serial_adc_emu_chk
    import adc_emu_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cs_lvl,
    input logic        shdn_lvl,
    input logic        sclk_rise,
    input logic        sclk_fall,
    input logic        start_ok,
    input logic        conv_done,
    input conv_state_t state_q,
    input logic        dout_o,
    input logic        dout_oe_o,
    input logic        proto_err_o
);

    // R1
    desel_undriven_chk: assert property (@(posedge clk) disable iff (rst)
        cs_lvl |=> !dout_oe_o);

    // R8
    sleep_undriven_chk: assert property (@(posedge clk) disable iff (rst)
        !shdn_lvl |=> !dout_oe_o);

    // R2
    start_drives_low_chk: assert property (@(posedge clk) disable iff (rst)
        start_ok |=> (state_q == ST_CONV && dout_oe_o && !dout_o));

    // R3
    marker_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV && conv_done && !cs_lvl && shdn_lvl) |=> (dout_oe_o && dout_o));

    // R4
    hold_without_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHIFT && !sclk_fall && !cs_lvl && shdn_lvl) |=> $stable(dout_o));

    // R10
    busy_clock_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV && (sclk_rise || sclk_fall)) |=> proto_err_o);

endmodule

bind serial_adc_emu serial_adc_emu_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_lvl      (cs_lvl),
    .shdn_lvl    (shdn_lvl),
    .sclk_rise   (sclk_rise),
    .sclk_fall   (sclk_fall),
    .start_ok    (start_ok),
    .conv_done   (conv_done),
    .state_q     (state_q),
    .dout_o      (dout_o),
    .dout_oe_o   (dout_oe_o),
    .proto_err_o (proto_err_o)
);

// File: tb/test_serial_adc_emu.sv
module test_serial_adc_emu;

    localparam int CONV = 20;
    localparam int CSH  = 5;
    localparam int ACQ  = 12;
    localparam int WAKE = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        shdn_n = 1'b1;
    logic [11:0] sample = '0;
    logic        dout, dout_oe, perr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    serial_adc_emu #(
        .DATA_W      (12),
        .CONV_CYC    (CONV),
        .CSH_CYC     (CSH),
        .ACQ_CYC     (ACQ),
        .WAKE_CYC    (WAKE),
        .SYNC_STAGES (2)
    ) i_serial_adc_emu (
        .clk         (clk),
        .rst         (rst),
        .cs_n_i      (cs_n),
        .sclk_i      (sclk),
        .shdn_n_i    (shdn_n),
        .sample_i    (sample),
        .dout_o      (dout),
        .dout_oe_o   (dout_oe),
        .proto_err_o (perr)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reads marker, 12 data bits, then `extra` padding bits
    task automatic read_frame(input logic [11:0] v, input int extra);
        sclk = 1'b1; tick(3);
        chk("R4 rise keeps marker", dout, 1'b1);
        for (int k = 0; k < 12; k++) begin
            sclk = 1'b0; tick(3);
            chk("R4 data bit", dout, v[11-k]);
            sclk = 1'b1; tick(3);
        end
        for (int k = 0; k < extra; k++) begin
            sclk = 1'b0; tick(3);
            chk("R5 trailing zero", dout, 1'b0);
            chk("R5 still driven", dout_oe, 1'b1);
            sclk = 1'b1; tick(3);
        end
        sclk = 1'b0; tick(3);
    endtask

    task automatic t_reset();
        tick(5); rst = 1'b0; tick(2);
        chk("R11 oe after reset", dout_oe, 1'b0);
        chk("R11 flag after reset", perr, 1'b0);
    endtask

    task automatic t_convert(input logic [11:0] v);
        cs_n = 1'b1; tick(20);
        chk("R1 idle undriven", dout_oe, 1'b0);
        sample = v; cs_n = 1'b0; tick(3);
        chk("R2 driven", dout_oe, 1'b1);
        chk("R2 low while busy", dout, 1'b0);
        sample = ~v;
        tick(CONV - 1);
        chk("R3 still busy", dout, 1'b0);
        tick(1);
        chk("R3 marker", dout, 1'b1);
        read_frame(v, 3);
        cs_n = 1'b1; tick(3);
        chk("R1 release undriven", dout_oe, 1'b0);
    endtask

    task automatic t_cs_gap();
        cs_n = 1'b1; tick(20);
        sample = 12'h5A5; cs_n = 1'b0; tick(3 + CONV);
        cs_n = 1'b1; tick(CSH - 1);
        cs_n = 1'b0; tick(4);
        chk("R7 short gap rejected", dout_oe, 1'b0);
        cs_n = 1'b1; tick(CSH);
        cs_n = 1'b0; tick(3);
        chk("R7 exact gap accepted", dout_oe, 1'b1);
        tick(CONV);
        chk("R7 accepted conversion completes", dout, 1'b1);
        cs_n = 1'b1; tick(3);
    endtask

    task automatic t_abort();
        cs_n = 1'b1; tick(20);
        sample = 12'h123; cs_n = 1'b0; tick(3 + 5);
        cs_n = 1'b1; tick(3);
        chk("R6 abort undriven", dout_oe, 1'b0);
        tick(ACQ - 4);
        cs_n = 1'b0; tick(4);
        chk("R6 start before recovery rejected", dout_oe, 1'b0);
        cs_n = 1'b1; tick(ACQ);
        sample = 12'hC3F; cs_n = 1'b0; tick(3);
        chk("R6 start after recovery accepted", dout_oe, 1'b1);
        tick(CONV);
        read_frame(12'hC3F, 0);
        cs_n = 1'b1; tick(3);
    endtask

    task automatic t_shutdown();
        cs_n = 1'b1; tick(20);
        sample = 12'h0F0; cs_n = 1'b0; tick(3 + 4);
        shdn_n = 1'b0; tick(3);
        chk("R8 power-down stops conversion", dout_oe, 1'b0);
        cs_n = 1'b1; tick(10);
        cs_n = 1'b0; tick(4);
        chk("R8 start ignored while down", dout_oe, 1'b0);
        cs_n = 1'b1; tick(5);
        shdn_n = 1'b1; tick(WAKE - 1);
        cs_n = 1'b0; tick(4);
        chk("R9 start during wake ignored", dout_oe, 1'b0);
        cs_n = 1'b1; shdn_n = 1'b0; tick(5);
        shdn_n = 1'b1; tick(WAKE);
        sample = 12'h9E1; cs_n = 1'b0; tick(3);
        chk("R9 start at wake limit accepted", dout_oe, 1'b1);
        tick(CONV);
        read_frame(12'h9E1, 1);
        cs_n = 1'b1; tick(3);
    endtask

    task automatic t_violation();
        cs_n = 1'b1; tick(20);
        sample = 12'h8C7; cs_n = 1'b0; tick(3);
        tick(3);
        sclk = 1'b1; tick(3);
        chk("R10 flag set by busy clock", perr, 1'b1);
        sclk = 1'b0; tick(3);
        tick(CONV - 10);
        chk("R10 busy unaffected", dout, 1'b0);
        tick(1);
        chk("R10 marker on time", dout, 1'b1);
        read_frame(12'h8C7, 0);
        cs_n = 1'b1; tick(3);
        chk("R10 flag sticky", perr, 1'b1);
        tick(20);
        cs_n = 1'b0; tick(3);
        chk("R10 flag cleared by start", perr, 1'b0);
        tick(CONV);
        cs_n = 1'b1; tick(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_convert(12'hA5C);
        t_convert(12'h000);
        t_convert(12'hFFF);
        t_convert(12'h3A6);
        t_cs_gap();
        t_abort();
        t_shutdown();
        t_violation();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule